// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six condition and control flags of a small 8-bit processor: negative, overflow, decimal, interrupt-disable, zero and carry. Each cycle it may take one flag update from the arithmetic and shift logic. That update carries the result byte, the carry-out, the overflow indication, an operand byte for bit-test instructions and a mask that picks which flags to write. It can also load the flags from a byte pulled off the stack.

It forms the byte that is written to the stack when flags are pushed. Four things can cause a push: the flag-push instruction, the software break, a maskable interrupt and a non-maskable interrupt. The two unstored bit positions of that byte are filled according to the cause. The block also gates the maskable interrupt request with the interrupt-disable flag. The non-maskable request always passes.

The decimal flag drives a decimal-mode output, which selects BCD add and subtract. A parameter builds the variant that ignores decimal mode. In that variant the output is tied low.

Top module: `cpu_flag_reg`

## Requirements
- R1: After reset the flags byte reads 8'h04: I is 1, and N, V, D, Z and C are 0.
- R2: When upd_en is high and pull_en is low, mask bit 5 writes N from result bit 7 and mask bit 1 writes Z, which is 1 exactly when the result is zero. A flag whose mask bit is 0 keeps its value.
- R3: On such an update, mask bit 0 writes C from upd_carry. Mask bit 4 writes V from upd_ovf when upd_vsel is 0, and from operand bit 6 when upd_vsel is 1.
- R4: On such an update, mask bit 3 writes D from upd_ctl_val and mask bit 2 writes I from upd_ctl_val.
- R5: When pull_en is high, flags bits 7, 6, 3, 2, 1 and 0 load from the same bits of pull_byte on the next edge, and any update in that cycle is discarded. Bits 5 and 4 of pull_byte have no effect.
- R6: push_byte carries the current flags in bits 7, 6, 3, 2, 1 and 0. Bits 5:4 depend on push_kind: 2'b11 for kind 0 (flag push) and kind 1 (break), and 2'b10 for kind 2 (maskable interrupt) and kind 3 (non-maskable interrupt).
- R7: A push of kind 1, 2 or 3 sets I to 1 at the second rising edge after the push is presented. At that edge the set overrides any pull or update of I. A push of kind 0 leaves I unchanged.
- R8: irq_out equals irq_req while I is 0 and is 0 while I is 1.
- R9: nmi_out equals nmi_req regardless of I.
- R10: dec_mode follows D when DEC_EN is 1 and is always 0 when DEC_EN is 0.
- R11: Bits 5 and 4 of flags always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Apply a flag update this cycle |
| upd_mask | input | 6 | Flag write mask: 5=N 4=V 3=D 2=I 1=Z 0=C |
| upd_result | input | 8 | Result byte of the operation |
| upd_operand | input | 8 | Operand byte read by a bit test |
| upd_carry | input | 1 | Carry-out (not-borrow after subtract) |
| upd_ovf | input | 1 | Signed overflow indication |
| upd_vsel | input | 1 | 1: V from operand bit 6 |
| upd_ctl_val | input | 1 | Value written to D or I by the mask |
| pull_en | input | 1 | Load flags from pull_byte |
| pull_byte | input | 8 | Byte pulled from the stack |
| push_en | input | 1 | A flag push is presented this cycle |
| push_kind | input | 2 | Push cause: 0 flag push, 1 break, 2 maskable, 3 non-maskable |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| flags | output | 8 | Flag byte, bits 5:4 zero |
| push_byte | output | 8 | Byte to write to the stack |
| dec_mode | output | 1 | Decimal arithmetic enable |
| irq_out | output | 1 | Gated maskable request |
| nmi_out | output | 1 | Non-maskable request |

## Verification
The hardest case to reach is the collision at the edge where a pending interrupt-disable set from an earlier interrupt push lands in the same cycle as a pull or update that clears I. The interrupt entry must win there. The stimulus reaches it directly: it presents a maskable-interrupt push and then, in the very next cycle, a pull of a byte with I clear, and it repeats this with an update that clears I. Random traffic then mixes pushes, pulls and masked updates at a density that brings back-to-back overlaps about once every few dozen cycles, and a behavioural model checks every cycle.

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg #(
  parameter bit DEC_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_en,
  input  logic [5:0] upd_mask,
  input  logic [7:0] upd_result,
  input  logic [7:0] upd_operand,
  input  logic       upd_carry,
  input  logic       upd_ovf,
  input  logic       upd_vsel,
  input  logic       upd_ctl_val,
  input  logic       pull_en,
  input  logic [7:0] pull_byte,
  input  logic       push_en,
  input  logic [1:0] push_kind,
  input  logic       irq_req,
  input  logic       nmi_req,
  output logic [7:0] flags,
  output logic [7:0] push_byte,
  output logic       dec_mode,
  output logic       irq_out,
  output logic       nmi_out
);

  localparam int PN = 7, PV = 6, PD = 3, PI = 2, PZ = 1, PC = 0;
  localparam int MN = 5, MV = 4, MD = 3, MI = 2, MZ = 1, MC = 0;

  logic n_q, v_q, d_q, i_q, z_q, c_q, i_pend;
  logic n_d, v_d, d_d, i_d, z_d, c_d;
  logic wr;

  assign wr = upd_en & ~pull_en;

  always_comb begin
    n_d = n_q; v_d = v_q; d_d = d_q; i_d = i_q; z_d = z_q; c_d = c_q;
    if (pull_en) begin
      n_d = pull_byte[PN];
      v_d = pull_byte[PV];
      d_d = pull_byte[PD];
      i_d = pull_byte[PI];
      z_d = pull_byte[PZ];
      c_d = pull_byte[PC];
    end else if (wr) begin
      if (upd_mask[MN]) n_d = upd_result[7];
      if (upd_mask[MV]) v_d = upd_vsel ? upd_operand[6] : upd_ovf;
      if (upd_mask[MD]) d_d = upd_ctl_val;
      if (upd_mask[MI]) i_d = upd_ctl_val;
      if (upd_mask[MZ]) z_d = (upd_result == 8'h00);
      if (upd_mask[MC]) c_d = upd_carry;
    end
    if (i_pend) i_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= 1'b0; v_q <= 1'b0; d_q <= 1'b0;
      i_q <= 1'b1; z_q <= 1'b0; c_q <= 1'b0;
      i_pend <= 1'b0;
    end else begin
      n_q <= n_d; v_q <= v_d; d_q <= d_d;
      i_q <= i_d; z_q <= z_d; c_q <= c_d;
      i_pend <= push_en & (push_kind != 2'd0);
    end
  end

  assign flags     = {n_q, v_q, 2'b00, d_q, i_q, z_q, c_q};
  assign push_byte = {n_q, v_q, 1'b1, ~push_kind[1], d_q, i_q, z_q, c_q};
  assign dec_mode  = DEC_EN ? d_q : 1'b0;
  assign irq_out   = irq_req & ~i_q;
  assign nmi_out   = nmi_req;

endmodule

module cpu_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_en,
  input logic [5:0] upd_mask,
  input logic [7:0] upd_result,
  input logic       pull_en,
  input logic [7:0] pull_byte,
  input logic       push_en,
  input logic [1:0] push_kind,
  input logic       irq_req,
  input logic       nmi_req,
  input logic [7:0] flags,
  input logic [7:0] push_byte,
  input logic       dec_mode,
  input logic       irq_out,
  input logic       nmi_out
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> flags == 8'h04);

  a_r2_n_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !pull_en && upd_mask[5]) |=> flags[7] == $past(upd_result[7]));

  a_r2_z_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !pull_en && upd_mask[1]) |=> flags[1] == ($past(upd_result) == 8'h00));

  a_r5_pull_loads: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en |=> {flags[7:6], flags[3], flags[1:0]} ==
                {$past(pull_byte[7:6]), $past(pull_byte[3]), $past(pull_byte[1:0])});

  a_r6_cause_bits: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> push_byte[5:4] == (push_kind[1] ? 2'b10 : 2'b11));

  a_r7_i_set: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && push_kind != 2'd0) |=> ##1 flags[2]);

  a_r8_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> !irq_out);

  a_r9_nmi_pass: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_out);

  a_r10_dec_needs_d: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mode |-> flags[3]);

  a_r11_unstored: assert property (@(posedge clk) disable iff (!rst_n)
    flags[5:4] == 2'b00);

endmodule

bind cpu_flag_reg cpu_flag_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_mask(upd_mask),
  .upd_result(upd_result), .pull_en(pull_en), .pull_byte(pull_byte),
  .push_en(push_en), .push_kind(push_kind), .irq_req(irq_req),
  .nmi_req(nmi_req), .flags(flags), .push_byte(push_byte),
  .dec_mode(dec_mode), .irq_out(irq_out), .nmi_out(nmi_out)
);

// File: tb/cpu_flag_reg_bench.sv
module cpu_flag_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_en = 1'b0;
  logic [5:0] upd_mask = '0;
  logic [7:0] upd_result = '0;
  logic [7:0] upd_operand = '0;
  logic       upd_carry = 1'b0;
  logic       upd_ovf = 1'b0;
  logic       upd_vsel = 1'b0;
  logic       upd_ctl_val = 1'b0;
  logic       pull_en = 1'b0;
  logic [7:0] pull_byte = '0;
  logic       push_en = 1'b0;
  logic [1:0] push_kind = '0;
  logic       irq_req = 1'b0;
  logic       nmi_req = 1'b0;
  logic [7:0] flags, push_byte, flags_nd, push_byte_nd;
  logic       dec_mode, irq_out, nmi_out, dec_mode_nd, irq_out_nd, nmi_out_nd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_flag_reg #(.DEC_EN(1'b1)) u_cpu_flag_reg (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_mask(upd_mask),
    .upd_result(upd_result), .upd_operand(upd_operand), .upd_carry(upd_carry),
    .upd_ovf(upd_ovf), .upd_vsel(upd_vsel), .upd_ctl_val(upd_ctl_val),
    .pull_en(pull_en), .pull_byte(pull_byte), .push_en(push_en),
    .push_kind(push_kind), .irq_req(irq_req), .nmi_req(nmi_req),
    .flags(flags), .push_byte(push_byte), .dec_mode(dec_mode),
    .irq_out(irq_out), .nmi_out(nmi_out));

  cpu_flag_reg #(.DEC_EN(1'b0)) u_cpu_flag_reg_nodec (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_mask(upd_mask),
    .upd_result(upd_result), .upd_operand(upd_operand), .upd_carry(upd_carry),
    .upd_ovf(upd_ovf), .upd_vsel(upd_vsel), .upd_ctl_val(upd_ctl_val),
    .pull_en(pull_en), .pull_byte(pull_byte), .push_en(push_en),
    .push_kind(push_kind), .irq_req(irq_req), .nmi_req(nmi_req),
    .flags(flags_nd), .push_byte(push_byte_nd), .dec_mode(dec_mode_nd),
    .irq_out(irq_out_nd), .nmi_out(nmi_out_nd));

  // behavioural reference model
  bit m_n, m_v, m_d, m_i, m_z, m_c, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 0; m_v = 0; m_d = 0; m_i = 1; m_z = 0; m_c = 0; m_pend = 0;
    end else begin
      if (pull_en) begin
        m_n = pull_byte[7]; m_v = pull_byte[6]; m_d = pull_byte[3];
        m_i = pull_byte[2]; m_z = pull_byte[1]; m_c = pull_byte[0];
      end else if (upd_en) begin
        if (upd_mask[5]) m_n = upd_result[7];
        if (upd_mask[4]) m_v = upd_vsel ? upd_operand[6] : upd_ovf;
        if (upd_mask[3]) m_d = upd_ctl_val;
        if (upd_mask[2]) m_i = upd_ctl_val;
        if (upd_mask[1]) m_z = (upd_result == 0);
        if (upd_mask[0]) m_c = upd_carry;
      end
      if (m_pend) m_i = 1;
      m_pend = push_en && (push_kind != 0);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_flags();
    return {m_n, m_v, 2'b00, m_d, m_i, m_z, m_c};
  endfunction

  task automatic compare_all();
    logic [7:0] pb;
    pb = {m_n, m_v, (push_kind < 2) ? 2'b11 : 2'b10, m_d, m_i, m_z, m_c};
    chk("R2 R3 R4 R5 R7 R11 flags", flags, exp_flags());
    chk("R6 push_byte", push_byte, pb);
    chk("R8 irq_out", {7'd0, irq_out}, {7'd0, irq_req & ~m_i});
    chk("R9 nmi_out", {7'd0, nmi_out}, {7'd0, nmi_req});
    chk("R10 dec_mode", {7'd0, dec_mode}, {7'd0, m_d});
    chk("R10 dec_mode variant", {7'd0, dec_mode_nd}, 8'd0);
    chk("R11 variant flags", flags_nd, exp_flags());
  endtask

  task automatic idle();
    upd_en = 0; pull_en = 0; push_en = 0; upd_mask = '0;
  endtask

  // advance one cycle: check at the negedge, then present new stimulus
  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flags", flags, 8'h04);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset after release", flags, 8'h04);
    chk("R8 irq blocked after reset", {7'd0, irq_out}, 8'd0);

    // R2: zero result with N, Z written
    idle(); upd_en = 1; upd_mask = 6'b100010; upd_result = 8'h00;
    tick(); idle();
    tick(); chk("R2 zero result", flags, 8'h06);
    upd_en = 1; upd_mask = 6'b100010; upd_result = 8'h80;
    tick(); idle();
    tick(); chk("R2 negative result", flags, 8'h84);

    // R3: carry and V from operand bit 6
    upd_en = 1; upd_mask = 6'b010001; upd_carry = 1; upd_vsel = 1; upd_operand = 8'h40;
    tick(); idle(); upd_vsel = 0;
    tick(); chk("R3 carry and bit-test V", flags, 8'hC5);

    // R4: clear I, set D
    upd_en = 1; upd_mask = 6'b000100; upd_ctl_val = 0;
    tick(); upd_mask = 6'b001000; upd_ctl_val = 1;
    tick(); idle();
    tick(); chk("R4 I clear D set", flags, 8'hC9);
    chk("R10 dec_mode follows D", {7'd0, dec_mode}, 8'd1);
    chk("R10 variant dec_mode low", {7'd0, dec_mode_nd}, 8'd0);
    irq_req = 1; nmi_req = 1;
    #1; chk("R8 irq passes when I clear", {7'd0, irq_out}, 8'd1);

    // R5: pull wins over update, bits 5:4 ignored
    pull_en = 1; pull_byte = 8'h30; upd_en = 1; upd_mask = 6'b111111; upd_result = 8'h80;
    tick(); idle();
    tick(); chk("R5 pull priority", flags, 8'h00);

    // R6/R7: flag push keeps I clear
    push_en = 1; push_kind = 0;
    #1; chk("R6 flag push bits", push_byte, 8'h30);
    tick(); idle();
    tick(); chk("R7 flag push leaves I", flags, 8'h00);

    // R7: maskable interrupt push, then pull clearing I next cycle
    push_en = 1; push_kind = 2;
    #1; chk("R6 maskable push bits", push_byte, 8'h20);
    tick(); idle(); pull_en = 1; pull_byte = 8'h01;
    tick(); idle();
    tick(); chk("R7 pending set beats pull", flags, 8'h05);
    chk("R9 nmi passes with I set", {7'd0, nmi_out}, 8'd1);

    // R7: break push then update clearing I
    upd_en = 1; upd_mask = 6'b000100; upd_ctl_val = 0;
    tick(); idle();
    push_en = 1; push_kind = 1;
    #1; chk("R6 break push bits", push_byte, 8'h31);
    tick(); idle(); upd_en = 1; upd_mask = 6'b000100; upd_ctl_val = 0;
    tick(); idle();
    tick(); chk("R7 pending set beats update", flags, 8'h05);
    push_en = 1; push_kind = 3;
    #1; chk("R6 non-maskable push bits", push_byte, 8'h25);
    tick(); idle();

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      upd_en      = ($urandom % 3) != 0;
      upd_mask    = 6'($urandom);
      upd_result  = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      upd_operand = 8'($urandom);
      upd_carry   = 1'($urandom);
      upd_ovf     = 1'($urandom);
      upd_vsel    = 1'($urandom);
      upd_ctl_val = 1'($urandom);
      pull_en     = ($urandom % 5) == 0;
      pull_byte   = 8'($urandom);
      push_en     = ($urandom % 6) == 0;
      push_kind   = 2'($urandom);
      irq_req     = 1'($urandom);
      nmi_req     = 1'($urandom);
      tick();
    end
    idle();
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule